// File: doc/BRIEF.md
# Board Control Register Bank

This block is a 4 KB window of 32-bit board control and identity registers. Software uses it to steer a boot-time address remap line, to drive a row of status LEDs, and to hold a few settings that only some FPGA images provide: a flash-interface select word, a bus clock frequency value in Hz, and a block-RAM clock divider. Whether those image-specific registers exist depends on a part-number field taken from a read-only identity value fixed by a parameter. The data bus is little-endian, so bit 0 of a data word is bit 0 of the register.

A lock-status register reports the state of a set of digital-locked loops. All loops are modelled as locked. Software can write only a lock mask. The summary bit reports whether every loop selected by that mask is locked. The DIP-switch register, the fixed configuration word and the two identity registers are constants. Accesses to unmapped offsets read as zero, are otherwise ignored, and raise a one-cycle `bad_access` flag.

The bus takes one word access per cycle whenever `bus_valid` is high and never applies back-pressure. A read returns `rd_data` with a one-cycle `rd_valid` pulse in the cycle after it is accepted. A write has no response; its effect is visible from the next cycle. Address bits [1:0] are ignored.

Top module: `board_ctl_bank`

## Requirements
- R1: After reset, offset 0x000 reads `CTRL0_RESET` and `remap` equals `CTRL0_RESET[0]`. The LED register, the image-specific registers and the lock mask all reset to zero, `led` is zero, and `rd_valid` and `bad_access` are low.
- R2: Every read accepted in cycle N gives `rd_valid`=1 and its data in cycle N+1. `rd_valid` is 0 in a cycle that follows a write or an idle cycle.
- R3: A write to offset 0x000 stores all 32 bits. From the next cycle, `remap` equals bit 0 of the written word, and `remap` changes at no other time.
- R4: A write to offset 0x004 stores its low `NUM_LEDS` bits, and these drive `led` (active high) from the next cycle. A read of 0x004 returns those bits with the upper bits zero.
- R5: Offsets 0x008 (flash select) and 0x014 (bus clock Hz) are full 32-bit read/write registers when the part number ID[15:4] is 0x524 or 0x547. For any other part number they read zero and ignore writes.
- R6: Offset 0x018 (block-RAM clock divider) is a 32-bit read/write register only when the part number is 0x524. Otherwise it reads zero and ignores writes.
- R7: Offset 0x00C (DIP switches) reads zero. Offsets 0x010, 0x030 and 0x034 read `CTRL4_VALUE`, `AUX_ID_VALUE` and `ID_VALUE`. Writes to all four have no effect.
- R8: At offset 0x020 only bits [31:24] are writable, and they hold the lock mask. Bits [23:16] read all ones (loops locked). Bit 0 reads 1, and all other bits read 0.
- R9: An access to any other offset reads zero and changes no register. In the next cycle it raises `bad_access` for one cycle, for reads and for writes alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle; always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| bad_access | output | 1 | Pulse: the previous access hit an unmapped offset |
| remap | output | 1 | Address remap control (bit 0 of offset 0x000) |
| led | output | NUM_LEDS | LED drive, active high |

## Verification
The bench runs three copies of the bank with part numbers 0x524, 0x547 and 0x511. The same writes go to all three, so a part-number decode that is wrong in either direction shows up: a missing register reads back zero, and an extra one reads back data. Other corner cases are also checked. Writes to constant and DIP registers must not change them, so a design that stored such a write returns it on the read. Lock-register writes with all ones must keep the low bits fixed, so a design that let the whole word be written returns extra bits. Unmapped accesses must raise the flag without changing any neighbour, and a decode that ignored the upper address bits would alias 0x800 onto 0x000. A reset in the middle of the run must clear the registers again.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int PART_LSB = 4;
  localparam int PART_W   = 12;

  localparam logic [ADDR_W-1:0] OFS_CTRL0  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_LED    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_FSEL   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DIP    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_CTRL4  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_BUSCLK = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_BRAMDV = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_AUXID  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_ID     = 12'h034;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL0, SEL_LED, SEL_FSEL, SEL_DIP, SEL_CTRL4,
    SEL_BUSCLK, SEL_BRAMDV, SEL_LOCK, SEL_AUXID, SEL_ID
  } reg_sel_e;

  function automatic logic part_has_fsel(input logic [PART_W-1:0] part);
    return (part == 12'h524) || (part == 12'h547);
  endfunction

  function automatic logic part_has_bramdv(input logic [PART_W-1:0] part);
    return part == 12'h524;
  endfunction

endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    unique case (addr[ADDR_W-1:2])
      OFS_CTRL0[ADDR_W-1:2]:  sel = SEL_CTRL0;
      OFS_LED[ADDR_W-1:2]:    sel = SEL_LED;
      OFS_FSEL[ADDR_W-1:2]:   sel = SEL_FSEL;
      OFS_DIP[ADDR_W-1:2]:    sel = SEL_DIP;
      OFS_CTRL4[ADDR_W-1:2]:  sel = SEL_CTRL4;
      OFS_BUSCLK[ADDR_W-1:2]: sel = SEL_BUSCLK;
      OFS_BRAMDV[ADDR_W-1:2]: sel = SEL_BRAMDV;
      OFS_LOCK[ADDR_W-1:2]:   sel = SEL_LOCK;
      OFS_AUXID[ADDR_W-1:2]:  sel = SEL_AUXID;
      OFS_ID[ADDR_W-1:2]:     sel = SEL_ID;
      default:                sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/board_ctl_image_regs.sv
module board_ctl_image_regs
  import board_ctl_pkg::*;
#(
  parameter logic [PART_W-1:0] PART = 12'h524
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] fsel_q,
  output logic [DATA_W-1:0] busclk_q,
  output logic [DATA_W-1:0] bramdv_q
);
  localparam bit HAS_FSEL   = part_has_fsel(PART);
  localparam bit HAS_BRAMDV = part_has_bramdv(PART);

  generate
    if (HAS_FSEL) begin : g_fsel
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fsel_q   <= '0;
          busclk_q <= '0;
        end else if (wr_en) begin
          if (sel == SEL_FSEL)   fsel_q   <= wdata;
          if (sel == SEL_BUSCLK) busclk_q <= wdata;
        end
      end
    end else begin : g_no_fsel
      assign fsel_q   = '0;
      assign busclk_q = '0;
    end

    if (HAS_BRAMDV) begin : g_bramdv
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          bramdv_q <= '0;
        else if (wr_en && sel == SEL_BRAMDV) bramdv_q <= wdata;
      end
    end else begin : g_no_bramdv
      assign bramdv_q = '0;
    end

    if (!HAS_FSEL && !HAS_BRAMDV) begin : g_idle
      logic unused_in;
      assign unused_in = ^{clk, rst_n, wr_en, sel, wdata};
    end
  endgenerate
endmodule

// File: rtl/board_ctl_lock.sv
module board_ctl_lock
  import board_ctl_pkg::*;
#(
  parameter int NUM_LOOPS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_LOOPS-1:0] mask_in,
  output logic [DATA_W-1:0]    word
);
  logic [NUM_LOOPS-1:0] mask_q;
  logic [NUM_LOOPS-1:0] locked;
  logic                 all_locked;

  assign locked = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_in;
  end

  assign all_locked = &(locked | ~mask_q);

  always_comb begin
    word                  = '0;
    word[24 +: NUM_LOOPS] = mask_q;
    word[16 +: NUM_LOOPS] = locked;
    word[0]               = all_locked;
  end
endmodule

// File: rtl/board_ctl_bank.sv
module board_ctl_bank
  import board_ctl_pkg::*;
#(
  parameter int          NUM_LEDS     = 8,
  parameter int          NUM_LOOPS    = 8,
  parameter logic [31:0] CTRL0_RESET  = 32'h0000_0000,
  parameter logic [31:0] CTRL4_VALUE  = 32'h0000_0000,
  parameter logic [31:0] ID_VALUE     = 32'h4104_5240,
  parameter logic [31:0] AUX_ID_VALUE = 32'h0000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  output logic                bad_access,
  output logic                remap,
  output logic [NUM_LEDS-1:0] led
);
  localparam logic [PART_W-1:0] PART = ID_VALUE[PART_LSB +: PART_W];

  reg_sel_e            sel;
  logic                wr_en;
  logic                rd_en;
  logic [DATA_W-1:0]   ctrl0_q;
  logic [NUM_LEDS-1:0] led_q;
  logic [DATA_W-1:0]   fsel_q, busclk_q, bramdv_q, lock_word;
  logic [DATA_W-1:0]   rdata_d;

  assign wr_en = bus_valid &  bus_write;
  assign rd_en = bus_valid & ~bus_write;

  board_ctl_decode u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  board_ctl_image_regs #(.PART(PART)) u_image (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .sel      (sel),
    .wdata    (bus_wdata),
    .fsel_q   (fsel_q),
    .busclk_q (busclk_q),
    .bramdv_q (bramdv_q)
  );

  board_ctl_lock #(.NUM_LOOPS(NUM_LOOPS)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en && sel == SEL_LOCK),
    .mask_in (bus_wdata[24 +: NUM_LOOPS]),
    .word    (lock_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_q <= CTRL0_RESET;
      led_q   <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CTRL0) ctrl0_q <= bus_wdata;
      if (sel == SEL_LED)   led_q   <= bus_wdata[NUM_LEDS-1:0];
    end
  end

  assign remap = ctrl0_q[0];
  assign led   = led_q;

  always_comb begin
    rdata_d = '0;
    unique case (sel)
      SEL_CTRL0:  rdata_d = ctrl0_q;
      SEL_LED:    rdata_d[NUM_LEDS-1:0] = led_q;
      SEL_FSEL:   rdata_d = fsel_q;
      SEL_DIP:    rdata_d = '0;
      SEL_CTRL4:  rdata_d = CTRL4_VALUE;
      SEL_BUSCLK: rdata_d = busclk_q;
      SEL_BRAMDV: rdata_d = bramdv_q;
      SEL_LOCK:   rdata_d = lock_word;
      SEL_AUXID:  rdata_d = AUX_ID_VALUE;
      SEL_ID:     rdata_d = ID_VALUE;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      bad_access <= 1'b0;
    end else begin
      rd_valid   <= rd_en;
      rd_data    <= rd_en ? rdata_d : '0;
      bad_access <= bus_valid && (sel == SEL_NONE);
    end
  end
endmodule

// File: rtl/board_ctl_bank_chk.sv
module board_ctl_bank_chk
  import board_ctl_pkg::*;
#(
  parameter int NUM_LEDS  = 8,
  parameter int NUM_LOOPS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [11:0]         bus_addr,
  input logic [31:0]         bus_wdata,
  input logic                rd_valid,
  input logic [31:0]         rd_data,
  input logic                bad_access,
  input logic                remap,
  input logic [NUM_LEDS-1:0] led
);
  logic rd_acc, wr_ctrl0, wr_led, rd_dip, rd_lock;
  assign rd_acc   = bus_valid && !bus_write;
  assign wr_ctrl0 = bus_valid && bus_write && bus_addr[11:2] == OFS_CTRL0[11:2];
  assign wr_led   = bus_valid && bus_write && bus_addr[11:2] == OFS_LED[11:2];
  assign rd_dip   = rd_acc && bus_addr[11:2] == OFS_DIP[11:2];
  assign rd_lock  = rd_acc && bus_addr[11:2] == OFS_LOCK[11:2];

  p_rd_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_valid);
  p_no_rd_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rd_valid);
  p_remap_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl0 |=> remap == $past(bus_wdata[0]));
  p_remap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl0 |=> $stable(remap));
  p_led_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_led |=> led == $past(bus_wdata[NUM_LEDS-1:0]));
  p_led_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_led |=> $stable(led));
  p_dip_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dip |=> rd_data == 32'h0);
  p_lock_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lock |=> (rd_data[16 +: NUM_LOOPS] == {NUM_LOOPS{1'b1}}) && rd_data[0]
                && (rd_data[15:1] == 15'h0));
  p_bad_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(bus_valid));
  p_bad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_access && rd_valid) |-> rd_data == 32'h0);
endmodule

bind board_ctl_bank board_ctl_bank_chk #(.NUM_LEDS(NUM_LEDS), .NUM_LOOPS(NUM_LOOPS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .bad_access (bad_access),
  .remap      (remap),
  .led        (led)
);

// File: tb/board_ctl_bank_bench.sv
module board_ctl_bank_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ID_A  = 32'h4104_5240;
  localparam logic [31:0] ID_B  = 32'h4104_5470;
  localparam logic [31:0] ID_C  = 32'h4104_5110;
  localparam logic [31:0] C4V   = 32'h0000_C4C4;
  localparam logic [31:0] AUXV  = 32'h0A11_0D01;
  localparam logic [31:0] RST_A = 32'h0000_0005;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] ea, eb, ec;
    logic        ebad;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0, RST_A, 32'h0, 32'h0, 1'b0, 4'd1},            // R1
    '{1'b0, 12'h020, 32'h0, 32'h00FF0001, 32'h00FF0001, 32'h00FF0001, 1'b0, 4'd1},
    '{1'b0, 12'h008, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 4'd1},
    '{1'b0, 12'h004, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 4'd1},
    '{1'b1, 12'h008, 32'hA5A50001, 32'h0, 32'h0, 32'h0, 1'b0, 4'd5},      // R5
    '{1'b0, 12'h008, 32'h0, 32'hA5A50001, 32'hA5A50001, 32'h0, 1'b0, 4'd5},
    '{1'b1, 12'h014, 32'h017D7840, 32'h0, 32'h0, 32'h0, 1'b0, 4'd5},
    '{1'b0, 12'h014, 32'h0, 32'h017D7840, 32'h017D7840, 32'h0, 1'b0, 4'd5},
    '{1'b1, 12'h018, 32'h00000003, 32'h0, 32'h0, 32'h0, 1'b0, 4'd6},      // R6
    '{1'b0, 12'h018, 32'h0, 32'h3, 32'h0, 32'h0, 1'b0, 4'd6},
    '{1'b1, 12'h00C, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 1'b0, 4'd7},      // R7
    '{1'b0, 12'h00C, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 4'd7},
    '{1'b1, 12'h010, 32'h12345678, 32'h0, 32'h0, 32'h0, 1'b0, 4'd7},
    '{1'b0, 12'h010, 32'h0, C4V, C4V, C4V, 1'b0, 4'd7},
    '{1'b1, 12'h034, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 4'd7},
    '{1'b0, 12'h034, 32'h0, ID_A, ID_B, ID_C, 1'b0, 4'd7},
    '{1'b0, 12'h030, 32'h0, AUXV, AUXV, AUXV, 1'b0, 4'd7},
    '{1'b1, 12'h020, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 1'b0, 4'd8},      // R8
    '{1'b0, 12'h020, 32'h0, 32'hFFFF0001, 32'hFFFF0001, 32'hFFFF0001, 1'b0, 4'd8},
    '{1'b1, 12'h020, 32'h5A000000, 32'h0, 32'h0, 32'h0, 1'b0, 4'd8},
    '{1'b0, 12'h020, 32'h0, 32'h5AFF0001, 32'h5AFF0001, 32'h5AFF0001, 1'b0, 4'd8},
    '{1'b1, 12'h004, 32'hFFFFFF3C, 32'h0, 32'h0, 32'h0, 1'b0, 4'd4},      // R4
    '{1'b0, 12'h004, 32'h0, 32'h3C, 32'h3C, 32'h3C, 1'b0, 4'd4},
    '{1'b0, 12'h006, 32'h0, 32'h3C, 32'h3C, 32'h3C, 1'b0, 4'd4},
    '{1'b1, 12'h800, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 1'b1, 4'd9},      // R9
    '{1'b0, 12'h800, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 4'd9},
    '{1'b0, 12'hFFC, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 4'd9},
    '{1'b0, 12'h02C, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 4'd9},
    '{1'b0, 12'h000, 32'h0, RST_A, 32'h0, 32'h0, 1'b0, 4'd9},
    '{1'b1, 12'h000, 32'hDEADBEEE, 32'h0, 32'h0, 32'h0, 1'b0, 4'd3},      // R3
    '{1'b0, 12'h000, 32'h0, 32'hDEADBEEE, 32'hDEADBEEE, 32'hDEADBEEE, 1'b0, 4'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rv_a, rv_b, rv_c, bad_a, bad_b, bad_c, remap_a, remap_b, remap_c;
  logic [31:0] rd_a, rd_b, rd_c;
  logic [7:0]  led_a, led_b, led_c;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  board_ctl_bank #(.CTRL0_RESET(RST_A), .CTRL4_VALUE(C4V), .ID_VALUE(ID_A),
                   .AUX_ID_VALUE(AUXV)) u_board_ctl_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rv_a), .rd_data(rd_a),
    .bad_access(bad_a), .remap(remap_a), .led(led_a));

  board_ctl_bank #(.CTRL4_VALUE(C4V), .ID_VALUE(ID_B), .AUX_ID_VALUE(AUXV)) u_board_ctl_bank_b (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rv_b), .rd_data(rd_b),
    .bad_access(bad_b), .remap(remap_b), .led(led_b));

  board_ctl_bank #(.CTRL4_VALUE(C4V), .ID_VALUE(ID_C), .AUX_ID_VALUE(AUXV)) u_board_ctl_bank_c (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rv_c), .rd_data(rd_c),
    .bad_access(bad_c), .remap(remap_c), .led(led_c));

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Drive one access at a falling edge; return at the next falling edge,
  // when the registered response of that access is on the outputs.
  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state at the pins
    check("R1 remap part524", {31'h0, remap_a}, 32'h1);
    check("R1 remap part547", {31'h0, remap_b}, 32'h0);
    check("R1 led", {24'h0, led_a}, 32'h0);
    check("R1 rd_valid idle", {31'h0, rv_a}, 32'h0);
    check("R1 bad_access idle", {31'h0, bad_a}, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d @%h", v.req, i, v.addr);
      access(v.wr, v.addr, v.wdata);
      check({tag, " bad"}, {31'h0, bad_a}, {31'h0, v.ebad});
      check({tag, " rd_valid"}, {31'h0, rv_a}, {31'h0, !v.wr});
      if (!v.wr) begin
        check({tag, " part524"}, rd_a, v.ea);
        check({tag, " part547"}, rd_b, v.eb);
        check({tag, " part511"}, rd_c, v.ec);
      end
    end

    // R2: response lasts one cycle, none after idle
    @(negedge clk);
    check("R2 rd_valid after idle", {31'h0, rv_a}, 32'h0);
    check("R9 bad_access after idle", {31'h0, bad_a}, 32'h0);

    // R3: remap follows bit 0
    check("R3 remap after even write", {31'h0, remap_a}, 32'h0);
    access(1'b1, 12'h000, 32'h0000_0001);
    check("R3 remap after odd write", {30'h0, remap_b, remap_a}, 32'h3);
    access(1'b1, 12'h004, 32'h0000_0000);
    check("R3 remap unaffected by LED write", {31'h0, remap_a}, 32'h1);

    // R4: LED pins
    access(1'b1, 12'h004, 32'h0000_01A5);
    check("R4 led pins", {24'h0, led_a}, 32'hA5);
    check("R4 led pins part511", {24'h0, led_c}, 32'hA5);

    // R1: mid-run reset clears writable state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 led after reset", {24'h0, led_a}, 32'h0);
    check("R1 remap after reset", {31'h0, remap_a}, 32'h1);
    access(1'b0, 12'h008, 32'h0);
    check("R1 flash select after reset", rd_a, 32'h0);
    access(1'b0, 12'h020, 32'h0);
    check("R1 lock mask after reset", rd_a, 32'h00FF0001);
    access(1'b0, 12'h000, 32'h0);
    check("R1 ctrl0 after reset", rd_a, RST_A);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule